// File: doc/BRIEF.md
# Chained Two-Stage Dual-Rail ALU

This block evaluates either a single arithmetic or logic operation or a chained pair of operations on 32-bit operands. Every data and code bit travels as a pair of rails (t, f), so each word carries its own validity. Words move under a four-phase return-to-empty handshake: a valid wave is followed by an all-empty wave. The sender supplies operands A, B and C and two 4-bit function codes. Stage one applies the first code to A and B. A zero second code sends the stage-one result straight to the output. A non-zero second code makes stage two apply that code to the stage-one result and C. This lets a multiply-accumulate, or any other pairing, complete as one request.

Inside each stage, a demultiplexer built from gating elements routes the operands to one function unit only. Every other unit sees only empty codewords. The results are merged by OR-ing the rails. Two clocked hold elements model the handshake latches behaviourally: one on the input side, whose validity is the acknowledge back to the sender, and one on the output side, whose validity is the done flag. The receiver answers done through its own acknowledge.

Top module: `chain_alu`

## Requirements
- R1: Every output bit pair (t,f) reads (0,0) for empty, (0,1) for a valid 0, (1,0) for a valid 1, and never reads (1,1). The same encoding applies to all input pairs.
- R2: First-stage codes select these results from A and B: 1 gives A+B, 2 gives A-B, 3 gives A[15:0]×B[15:0] as a 32-bit product, 4 gives A AND B, 5 gives A OR B, 6 gives A shifted left by B[4:0], 7 gives A shifted right logically by B[4:0], and 8 passes A. Codes 0 and 9 to 15 also pass A.
- R3: When the second code is 0000, the result equals the stage-one result unchanged.
- R4: When the second code is non-zero, the result is that code's operation (same numbering as R2) applied to the stage-one result as first operand and C as second operand. Codes 9 to 15 pass the stage-one result.
- R5: First code 3 followed by second code 1 yields C + A[15:0]×B[15:0], modulo 2^32, in one request.
- R6: Within each stage, at most one function unit receives a non-empty operand pair. The bypass path and the stage-two path are never non-empty at the same time.
- R7: Assume done and rx_ack are low and every input pair (A, B, C, both codes) is valid. Then in_ack rises one clock later and done rises two clocks later. While done is high, every result pair is valid.
- R8: Assume done is high, every input pair is empty and rx_ack is high. Then in_ack falls one clock later, and done falls with all result pairs empty two clocks later.
- R9: While rx_ack stays low, done stays high and the result stays unchanged, even after the inputs have returned to empty.
- R10: While any input pair is still empty, nothing is captured: in_ack and done stay low.
- R11: Synchronous active-high reset clears done, in_ack and all result rails to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_t | input | 32 | Operand A, true rails |
| a_f | input | 32 | Operand A, false rails |
| b_t | input | 32 | Operand B, true rails |
| b_f | input | 32 | Operand B, false rails |
| c_t | input | 32 | Operand C (stage-two second operand), true rails |
| c_f | input | 32 | Operand C, false rails |
| fsel1_t | input | 4 | First-stage function code, true rails |
| fsel1_f | input | 4 | First-stage function code, false rails |
| fsel2_t | input | 4 | Second-stage function code, true rails |
| fsel2_f | input | 4 | Second-stage function code, false rails |
| rx_ack | input | 1 | Receiver acknowledge of the result |
| in_ack | output | 1 | Acknowledge to the sender: input hold is valid |
| res_t | output | 32 | Result, true rails |
| res_f | output | 32 | Result, false rails |
| done | output | 1 | All result pairs valid |

## Verification
The bypass path and the stage-two path feed the same OR merge. They can never carry data in the same wave, but they alternate from one request to the next. The bench interleaves requests whose second code is zero with requests that chain through stage two, and compares each result with a behavioural model. A leftover codeword on the inactive path would show up as a wrong value or a (1,1) pair. A second overlap arises in the empty wave: the input hold releases while the output hold is still full. The bench holds rx_ack low across that window and checks that in_ack falls while done and the result stay fixed.

// File: rtl/calu_pkg.sv
package calu_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned CODE_W  = 4;
    localparam int unsigned MUL_W   = 16;
    localparam int unsigned SH_W    = $clog2(DATA_W);
    localparam int unsigned N_UNITS = 8;

    typedef enum logic [CODE_W-1:0] {
        OP_NONE = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_MUL  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_SHL  = 4'd6,
        OP_SHR  = 4'd7,
        OP_PASS = 4'd8
    } calu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] t;
        logic [DATA_W-1:0] f;
    } dr_word_t;

    function automatic logic [DATA_W-1:0] calu_apply(
        input logic [CODE_W-1:0] op,
        input logic [DATA_W-1:0] x,
        input logic [DATA_W-1:0] y
    );
        logic [DATA_W-1:0] r;
        case (calu_op_e'(op))
            OP_ADD:  r = x + y;
            OP_SUB:  r = x - y;
            OP_MUL:  r = DATA_W'(x[MUL_W-1:0]) * DATA_W'(y[MUL_W-1:0]);
            OP_AND:  r = x & y;
            OP_OR:   r = x | y;
            OP_SHL:  r = x << y[SH_W-1:0];
            OP_SHR:  r = x >> y[SH_W-1:0];
            default: r = x;
        endcase
        return r;
    endfunction

    // map a raw code onto the unit number that serves it; unknown codes pass
    function automatic logic [CODE_W-1:0] calu_route(input logic [CODE_W-1:0] code);
        if (code >= CODE_W'(OP_ADD) && code <= CODE_W'(OP_PASS))
            return code;
        return CODE_W'(OP_PASS);
    endfunction

endpackage

// File: rtl/calu_hold.sv
module calu_hold #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_t,
    input  logic [WIDTH-1:0] d_f,
    input  logic             nxt_ph,
    output logic [WIDTH-1:0] q_t,
    output logic [WIDTH-1:0] q_f,
    output logic             ph
);
    logic d_full;
    logic d_void;

    assign d_full = &(d_t | d_f);
    assign d_void = ~|(d_t | d_f);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_t <= '0;
            q_f <= '0;
            ph  <= 1'b0;
        end else if (!ph && d_full && !nxt_ph) begin
            q_t <= d_t;
            q_f <= d_f;
            ph  <= 1'b1;
        end else if (ph && d_void && nxt_ph) begin
            q_t <= '0;
            q_f <= '0;
            ph  <= 1'b0;
        end
    end

    // R7
    hold_fill_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ph) |-> $past(!nxt_ph));
    // R8
    hold_drain_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ph) |-> $past(nxt_ph));
    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ph && $past(ph)) |-> ($stable(q_t) && $stable(q_f)));
endmodule

// File: rtl/calu_unit.sv
module calu_unit
    import calu_pkg::*;
#(
    parameter logic [CODE_W-1:0] OP_CODE = 4'd1
) (
    input  logic [DATA_W-1:0] x_t,
    input  logic [DATA_W-1:0] x_f,
    input  logic [DATA_W-1:0] y_t,
    input  logic [DATA_W-1:0] y_f,
    output logic [DATA_W-1:0] r_t,
    output logic [DATA_W-1:0] r_f
);
    logic              in_ok;
    logic [DATA_W-1:0] val;

    assign in_ok = (&(x_t | x_f)) && (&(y_t | y_f));
    assign val   = calu_apply(OP_CODE, x_t, y_t);
    assign r_t   = in_ok ? val  : '0;
    assign r_f   = in_ok ? ~val : '0;
endmodule

// File: rtl/calu_stage.sv
module calu_stage
    import calu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              gate,
    input  logic [DATA_W-1:0] x_t,
    input  logic [DATA_W-1:0] x_f,
    input  logic [DATA_W-1:0] y_t,
    input  logic [DATA_W-1:0] y_f,
    input  logic [CODE_W-1:0] code_t,
    input  logic [CODE_W-1:0] code_f,
    output logic [DATA_W-1:0] r_t,
    output logic [DATA_W-1:0] r_f
);
    logic                code_ok;
    logic [CODE_W-1:0]   idx;
    logic [N_UNITS-1:0]  sel;
    logic [N_UNITS-1:0]  busy;
    logic [DATA_W-1:0]   ut [N_UNITS];
    logic [DATA_W-1:0]   uf [N_UNITS];

    assign code_ok = &(code_t | code_f);
    assign idx     = calu_route(code_t);

    for (genvar k = 0; k < N_UNITS; k++) begin : g_unit
        logic [DATA_W-1:0] ax_t, ax_f, ay_t, ay_f;
        assign sel[k] = gate && code_ok && (idx == CODE_W'(k + 1));
        // demultiplexer leg: only the chosen unit sees a non-empty codeword
        assign ax_t = x_t & {DATA_W{sel[k]}};
        assign ax_f = x_f & {DATA_W{sel[k]}};
        assign ay_t = y_t & {DATA_W{sel[k]}};
        assign ay_f = y_f & {DATA_W{sel[k]}};
        assign busy[k] = |(ax_t | ax_f | ay_t | ay_f);
        calu_unit #(.OP_CODE(CODE_W'(k + 1))) u_fn (
            .x_t(ax_t), .x_f(ax_f), .y_t(ay_t), .y_f(ay_f),
            .r_t(ut[k]), .r_f(uf[k])
        );
    end

    // merge: plain OR of the rails, at most one leg is non-empty
    always_comb begin
        r_t = '0;
        r_f = '0;
        for (int k = 0; k < N_UNITS; k++) begin
            r_t = r_t | ut[k];
            r_f = r_f | uf[k];
        end
    end

    // R6
    one_unit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(busy));
    // R6
    idle_stage_chk: assert property (@(posedge clk) disable iff (rst)
        !gate |-> ~|(r_t | r_f));
endmodule

// File: rtl/chain_alu.sv
module chain_alu
    import calu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_t,
    input  logic [DATA_W-1:0] a_f,
    input  logic [DATA_W-1:0] b_t,
    input  logic [DATA_W-1:0] b_f,
    input  logic [DATA_W-1:0] c_t,
    input  logic [DATA_W-1:0] c_f,
    input  logic [CODE_W-1:0] fsel1_t,
    input  logic [CODE_W-1:0] fsel1_f,
    input  logic [CODE_W-1:0] fsel2_t,
    input  logic [CODE_W-1:0] fsel2_f,
    input  logic              rx_ack,
    output logic              in_ack,
    output logic [DATA_W-1:0] res_t,
    output logic [DATA_W-1:0] res_f,
    output logic              done
);
    localparam int unsigned IN_W = 3 * DATA_W + 2 * CODE_W;

    logic [IN_W-1:0]   h_t, h_f;
    dr_word_t          ha, hb, hc, r1, s2x, byp, r2, fin;
    logic [CODE_W-1:0] hf1_t, hf1_f, hf2_t, hf2_f;
    logic              f2_ok, chain_on, to_stage2, to_out;

    calu_hold #(.WIDTH(IN_W)) u_in_hold (
        .clk(clk), .rst(rst),
        .d_t({fsel2_t, fsel1_t, c_t, b_t, a_t}),
        .d_f({fsel2_f, fsel1_f, c_f, b_f, a_f}),
        .nxt_ph(done),
        .q_t(h_t), .q_f(h_f), .ph(in_ack)
    );

    assign ha.t  = h_t[DATA_W-1:0];
    assign ha.f  = h_f[DATA_W-1:0];
    assign hb.t  = h_t[2*DATA_W-1:DATA_W];
    assign hb.f  = h_f[2*DATA_W-1:DATA_W];
    assign hc.t  = h_t[3*DATA_W-1:2*DATA_W];
    assign hc.f  = h_f[3*DATA_W-1:2*DATA_W];
    assign hf1_t = h_t[3*DATA_W+CODE_W-1:3*DATA_W];
    assign hf1_f = h_f[3*DATA_W+CODE_W-1:3*DATA_W];
    assign hf2_t = h_t[IN_W-1:3*DATA_W+CODE_W];
    assign hf2_f = h_f[IN_W-1:3*DATA_W+CODE_W];

    calu_stage u_stage1 (
        .clk(clk), .rst(rst), .gate(1'b1),
        .x_t(ha.t), .x_f(ha.f), .y_t(hb.t), .y_f(hb.f),
        .code_t(hf1_t), .code_f(hf1_f),
        .r_t(r1.t), .r_f(r1.f)
    );

    // stage-two enable: OR of the second code bits, once that code is valid
    assign f2_ok     = &(hf2_t | hf2_f);
    assign chain_on  = |hf2_t;
    assign to_stage2 = f2_ok && chain_on;
    assign to_out    = f2_ok && !chain_on;

    assign s2x.t = r1.t & {DATA_W{to_stage2}};
    assign s2x.f = r1.f & {DATA_W{to_stage2}};
    assign byp.t = r1.t & {DATA_W{to_out}};
    assign byp.f = r1.f & {DATA_W{to_out}};

    calu_stage u_stage2 (
        .clk(clk), .rst(rst), .gate(to_stage2),
        .x_t(s2x.t), .x_f(s2x.f), .y_t(hc.t), .y_f(hc.f),
        .code_t(hf2_t), .code_f(hf2_f),
        .r_t(r2.t), .r_f(r2.f)
    );

    assign fin.t = byp.t | r2.t;
    assign fin.f = byp.f | r2.f;

    calu_hold #(.WIDTH(2 * DATA_W)) u_out_hold (
        .clk(clk), .rst(rst),
        .d_t({fin.t, fin.f} & {2*DATA_W{1'b1}}),
        .d_f({fin.f, fin.t}),
        .nxt_ph(rx_ack),
        .q_t({res_t, res_f}), .q_f(), .ph(done)
    );

    // R1
    no_both_rails_chk: assert property (@(posedge clk) disable iff (rst)
        ~|(res_t & res_f));
    // R6
    merge_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !((|(byp.t | byp.f)) && (|(r2.t | r2.f))));
    // R7
    done_full_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (&(res_t | res_f)));
    // R8
    done_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> ~|(res_t | res_f));
endmodule

// File: tb/chain_alu_test.sv
module chain_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0, c_t = '0, c_f = '0;
    logic [3:0]  fsel1_t = '0, fsel1_f = '0, fsel2_t = '0, fsel2_f = '0;
    logic        rx_ack = 1'b0;
    logic        in_ack, done;
    logic [31:0] res_t, res_f;

    int n_chk = 0;
    int n_bad = 0;
    bit over  = 1'b0;

    always #2.5 clk = ~clk;

    chain_alu uut (
        .clk(clk), .rst(rst),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .c_t(c_t), .c_f(c_f),
        .fsel1_t(fsel1_t), .fsel1_f(fsel1_f), .fsel2_t(fsel2_t), .fsel2_f(fsel2_f),
        .rx_ack(rx_ack), .in_ack(in_ack),
        .res_t(res_t), .res_f(res_f), .done(done)
    );

    function automatic logic [31:0] model_op(input int code, input logic [31:0] x, input logic [31:0] y);
        longint unsigned p;
        case (code)
            1: return x + y;
            2: return x - y;
            3: begin p = longint'(x & 32'hFFFF) * longint'(y & 32'hFFFF); return p[31:0]; end
            4: return x & y;
            5: return x | y;
            6: return x << (y % 32);
            7: return x >> (y % 32);
            default: return x;
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] c, input int f1, input int f2);
        logic [31:0] s1;
        s1 = model_op(f1, a, b);
        if (f2 == 0) return s1;
        return model_op(f2, s1, c);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1: per-clock rail legality and done/result agreement
    always @(negedge clk) begin
        if (!rst && !over) begin
            check((res_t & res_f) == 0, "R1 illegal pair", {res_t, res_f}, 64'h0);
            if (done) check((res_t | res_f) == 32'hFFFF_FFFF, "R7 valid while done", {32'h0, res_t | res_f}, 64'hFFFF_FFFF);
        end
    end

    task automatic drive_valid(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                               input int f1, input int f2, input bit c_valid);
        a_t = a; a_f = ~a; b_t = b; b_f = ~b;
        c_t = c_valid ? c : '0; c_f = c_valid ? ~c : '0;
        fsel1_t = 4'(f1); fsel1_f = ~4'(f1);
        fsel2_t = 4'(f2); fsel2_f = ~4'(f2);
    endtask

    task automatic drive_empty();
        a_t = '0; a_f = '0; b_t = '0; b_f = '0; c_t = '0; c_f = '0;
        fsel1_t = '0; fsel1_f = '0; fsel2_t = '0; fsel2_f = '0;
    endtask

    task automatic await_result(input logic [31:0] exp, input string req);
        @(posedge clk); @(negedge clk);
        check(in_ack == 1'b1 && done == 1'b0, "R7 in_ack one clock", {62'h0, in_ack, done}, 64'h2);
        @(posedge clk); @(negedge clk);
        check(done == 1'b1, "R7 done two clocks", {63'h0, done}, 64'h1);
        check(res_t == exp && res_f == ~exp, req, {res_t, res_f}, {exp, ~exp});
    endtask

    task automatic return_empty();
        drive_empty();
        rx_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        check(in_ack == 1'b0, "R8 in_ack falls", {63'h0, in_ack}, 64'h0);
        @(posedge clk); @(negedge clk);
        check(done == 1'b0 && (res_t | res_f) == 0, "R8 empty result", {31'h0, done, res_t | res_f}, 64'h0);
        rx_ack = 1'b0;
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input int f1, input int f2, input string req);
        drive_valid(a, b, c, f1, f2, 1'b1);
        await_result(model(a, b, c, f1, f2), req);
        return_empty();
    endtask

    initial begin
        #(200000 * 5);
        if (!over) begin
            over = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11
        check(done == 0 && in_ack == 0 && res_t == 0 && res_f == 0, "R11 reset state",
              {30'h0, done, in_ack, res_t | res_f}, 64'h0);

        // R2 / R3 single operations, bypassing stage two
        for (int op = 1; op <= 8; op++)
            run(32'hF00D_1234 + 32'(op), 32'h0000_8005, 32'hDEAD_BEEF, op, 0, "R2 R3 single op");
        run(32'h1357_9BDF, 32'h1, 32'h0, 0, 0, "R2 code zero passes A");
        run(32'hCAFE_0001, 32'h2, 32'h0, 12, 0, "R2 code twelve passes A");
        run(32'h8000_0001, 32'd31, 32'h0, 6, 0, "R2 shift by 31");
        run(32'h8000_0001, 32'd32, 32'h0, 7, 0, "R2 shift amount uses B[4:0]");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 3, 0, "R2 max 16x16 product");

        // R5 multiply then add, alternating with bypass requests (R6)
        run(32'h0001_0003, 32'h7777_0005, 32'h0000_0100, 3, 1, "R5 multiply-accumulate");
        run(32'h0000_0010, 32'h0000_0020, 32'h0, 1, 0, "R6 bypass after chain");
        run(32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 3, 1, "R5 MAC wraparound");

        // R4 chained pairs
        run(32'd100, 32'd50, 32'd30, 1, 2, "R4 add then subtract");
        run(32'h0000_00F0, 32'h0000_000F, 32'd4, 5, 6, "R4 or then shift left");
        run(32'h1234_5678, 32'h0000_0003, 32'h0F0F_0F0F, 6, 4, "R4 shift then and");
        run(32'h0000_0005, 32'h0000_0006, 32'h9999_9999, 1, 9, "R4 code nine passes stage one");

        // R9 output held while receiver has not acknowledged
        drive_valid(32'd7, 32'd9, 32'd1, 1, 3, 1'b1);
        await_result(model(32'd7, 32'd9, 32'd1, 1, 3), "R4 add then multiply");
        drive_empty();
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(done == 1'b1 && res_t == 32'd16 * 32'd1 && res_f == ~32'd16, "R9 result held",
              {res_t, res_f}, {32'd16, ~32'd16});
        check(in_ack == 1'b0, "R9 input side released", {63'h0, in_ack}, 64'h0);
        rx_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        check(done == 1'b0 && (res_t | res_f) == 0, "R8 drain after late ack", {31'h0, done, res_t | res_f}, 64'h0);
        rx_ack = 1'b0;

        // R10 incomplete wave is not captured
        drive_valid(32'd11, 32'd22, 32'd33, 1, 1, 1'b0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(in_ack == 1'b0 && done == 1'b0, "R10 partial wave ignored", {62'h0, in_ack, done}, 64'h0);
        drive_valid(32'd11, 32'd22, 32'd33, 1, 1, 1'b1);
        await_result(32'd66, "R10 completes once C valid");
        return_empty();

        over = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule